// File: doc/BRIEF.md
# 100 Mbps Link Integrity Monitor

This block decides whether a 100 Mbps copper link may be considered up. It watches two signals from the receive path: a level that says the descrambler is locked, and a per-symbol strobe with a flag that marks the symbol as an idle code group. The link is declared up only after the lock has held without a break for a long qualification time. From then on, the link stays up only while every monitoring window contains a run of consecutive idle symbols of a minimum length. Any loss of lock, or a window that expires without such a run, takes the link down and restarts the qualification.

From the link state the block derives everything its neighbours need. It gives a real-time link level and a management status bit that latches low on failure until software reads it. It raises a one-cycle renegotiate request when auto-negotiation is enabled. It drives a transmit-allow gate that a link-failure override can open only while auto-negotiation is disabled. It also gives a fast-link-pulse burst request for the auto-negotiation engine while the link is down. All timer lengths are parameters counted in clock cycles, so a simulation can use short values and silicon can use the real ones (about 50 ms and 2 ms).

Top module: `link100_integrity_mon`

## Requirements
- R1: After reset, link_up_o, stat_latched_o and reneg_req_o are 0. flp_req_o equals an_enable_i. tx_allow_o equals fail_override_i AND NOT an_enable_i.
- R2: link_up_o rises at the clock edge that samples lock_i high for the QUAL_CYCLES-th consecutive time, counting from reset, from the last low sample, or from the last link failure.
- R3: A low sample of lock_i drops link_up_o at that edge and restarts the qualification count from zero.
- R4: While the link is up, a symbol counts when sym_valid_i is 1. A counted symbol with sym_idle_i=1 extends the idle run, a counted symbol with sym_idle_i=0 clears it, and cycles with sym_valid_i=0 leave it unchanged. Suppose WIN_CYCLES clock cycles pass, counting from link-up or from the last window restart, without the run reaching RUN_LEN. The link then drops at the next edge, and qualification restarts from zero.
- R5: Each time the idle run reaches RUN_LEN, the window restarts and the run starts again from zero, so a steady idle stream keeps the link up indefinitely.
- R6: reneg_req_o is a one-cycle pulse. It is high in the first cycle in which link_up_o is low after a link failure, and only if an_enable_i was 1 at the failing edge.
- R7: stat_latched_o goes to 0 at a link failure and holds until a cycle with stat_read_i=1. That edge loads the link state of the reading cycle. When a failure and a read fall on the same edge, the failure wins.
- R8: tx_allow_o is 1 while the link is up. While the link is down it is 1 only if fail_override_i=1 and an_enable_i=0.
- R9: flp_req_o is 1 exactly when an_enable_i=1 and the link is down, and it is never high together with tx_allow_o.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| lock_i | input | 1 | Descrambler lock level |
| sym_valid_i | input | 1 | One received symbol this cycle |
| sym_idle_i | input | 1 | The symbol this cycle is an idle code group |
| an_enable_i | input | 1 | Auto-negotiation enabled |
| fail_override_i | input | 1 | Link-failure override for transmit |
| stat_read_i | input | 1 | Management read strobe for the latched status bit |
| link_up_o | output | 1 | Real-time link status |
| stat_latched_o | output | 1 | Latched-low link status for management |
| reneg_req_o | output | 1 | Renegotiate request pulse |
| tx_allow_o | output | 1 | Data transmit permitted |
| flp_req_o | output | 1 | Request fast-link-pulse bursts |

## Verification
The embedded assertions check on every cycle that a low lock sample takes the link down at the next edge. They also check that the idle run and the window age stay inside their bounds, and that a window timeout occurs only while the link is up. Beyond that, they check that the latched status bit rises only after a read, that the renegotiate request is a single cycle with auto-negotiation enabled and the link down, and that the transmit gate and the burst request are never high together. Only the bench's scenarios can show the exact qualification length, the timeout after a window without a long enough idle run, and the window restart when a run completes. The same holds for the rule that symbol gaps do not break a run and for the priority of a failure over a coincident read. For these the bench compares all outputs each clock against a behavioural model.

// File: rtl/lnkmon_pkg.sv
package lnkmon_pkg;

    // State of the management-facing part of the monitor.
    typedef struct packed {
        logic stat_lat;
        logic reneg;
    } report_state_t;

    // Width needed to hold a count of 0..n.
    function automatic int unsigned cnt_width(input int unsigned n);
        return (n < 2) ? 1 : $clog2(n + 1);
    endfunction

endpackage

// File: rtl/lnkmon_lock_qual.sv
module lnkmon_lock_qual #(
    parameter int unsigned QUAL_CYCLES = 6_250_000
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic lock_i,
    input  logic restart_i,
    output logic up_o,
    output logic drop_o
);
    import lnkmon_pkg::*;

    localparam int unsigned QW = cnt_width(QUAL_CYCLES);
    localparam logic [QW-1:0] LAST = QW'(QUAL_CYCLES - 1);

    typedef struct packed {
        logic [QW-1:0] cnt;
        logic          up;
    } qual_state_t;

    qual_state_t s_d, s_q;
    logic        clear;

    always_comb begin
        s_d   = s_q;
        clear = ~lock_i | restart_i;
        if (clear) begin
            s_d.cnt = '0;
            s_d.up  = 1'b0;
        end else if (!s_q.up) begin
            if (s_q.cnt == LAST) begin
                s_d.cnt = '0;
                s_d.up  = 1'b1;
            end else begin
                s_d.cnt = s_q.cnt + 1'b1;
            end
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign up_o   = s_q.up;
    assign drop_o = s_q.up & clear;

    // R3
    lock_loss_drops_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !lock_i |=> !up_o);

    // R2
    rise_needs_lock_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(up_o) |-> $past(lock_i));

    // R2
    qual_cnt_bound_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        s_q.cnt < QW'(QUAL_CYCLES));

endmodule

// File: rtl/lnkmon_idle_watch.sv
module lnkmon_idle_watch #(
    parameter int unsigned WIN_CYCLES = 250_000,
    parameter int unsigned RUN_LEN    = 16
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic active_i,
    input  logic sym_valid_i,
    input  logic sym_idle_i,
    output logic timeout_o
);
    import lnkmon_pkg::*;

    localparam int unsigned WW = cnt_width(WIN_CYCLES);
    localparam int unsigned RW = cnt_width(RUN_LEN);
    localparam logic [WW-1:0] WIN_LAST = WW'(WIN_CYCLES - 1);
    localparam logic [RW-1:0] RUN_LAST = RW'(RUN_LEN - 1);

    typedef struct packed {
        logic [RW-1:0] run;
        logic [WW-1:0] age;
    } watch_state_t;

    watch_state_t s_d, s_q;
    logic         run_done;
    logic         expire;

    always_comb begin
        s_d      = s_q;
        run_done = 1'b0;
        expire   = 1'b0;
        if (!active_i) begin
            s_d = '0;
        end else begin
            run_done = sym_valid_i & sym_idle_i & (s_q.run == RUN_LAST);
            expire   = ~run_done & (s_q.age == WIN_LAST);
            if (sym_valid_i) begin
                s_d.run = sym_idle_i ? s_q.run + 1'b1 : '0;
            end
            if (run_done || expire) begin
                s_d.run = '0;
                s_d.age = '0;
            end else begin
                s_d.age = s_q.age + 1'b1;
            end
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign timeout_o = expire;

    // R4
    window_age_bound_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        s_q.age < WW'(WIN_CYCLES));

    // R5
    idle_run_bound_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        s_q.run < RW'(RUN_LEN));

    // R4
    timeout_only_active_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        timeout_o |-> active_i);

endmodule

// File: rtl/lnkmon_report.sv
module lnkmon_report (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic link_up_i,
    input  logic drop_i,
    input  logic an_enable_i,
    input  logic fail_override_i,
    input  logic stat_read_i,
    output logic stat_latched_o,
    output logic reneg_o,
    output logic tx_allow_o,
    output logic flp_req_o
);
    import lnkmon_pkg::*;

    report_state_t s_d, s_q;

    always_comb begin
        s_d       = s_q;
        s_d.reneg = drop_i & an_enable_i;
        if (drop_i) begin
            s_d.stat_lat = 1'b0;
        end else if (stat_read_i) begin
            s_d.stat_lat = link_up_i;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign stat_latched_o = s_q.stat_lat;
    assign reneg_o        = s_q.reneg;
    assign tx_allow_o     = link_up_i | (fail_override_i & ~an_enable_i);
    assign flp_req_o      = an_enable_i & ~link_up_i;

    // R7
    latched_rise_on_read_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(stat_latched_o) |-> $past(stat_read_i));

    // R6
    reneg_with_an_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        reneg_o |-> ($past(an_enable_i) && !link_up_i));

    // R6
    reneg_single_cycle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        reneg_o |=> !reneg_o);

    // R9
    tx_flp_exclusive_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $onehot0({tx_allow_o, flp_req_o}));

endmodule

// File: rtl/link100_integrity_mon.sv
module link100_integrity_mon #(
    parameter int unsigned QUAL_CYCLES = 6_250_000,
    parameter int unsigned WIN_CYCLES  = 250_000,
    parameter int unsigned RUN_LEN     = 16
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic lock_i,
    input  logic sym_valid_i,
    input  logic sym_idle_i,
    input  logic an_enable_i,
    input  logic fail_override_i,
    input  logic stat_read_i,
    output logic link_up_o,
    output logic stat_latched_o,
    output logic reneg_req_o,
    output logic tx_allow_o,
    output logic flp_req_o
);
    logic link_up;
    logic link_drop;
    logic idle_timeout;

    lnkmon_lock_qual #(
        .QUAL_CYCLES (QUAL_CYCLES)
    ) i_qual (
        .clk_i     (clk_i),
        .rst_ni    (rst_ni),
        .lock_i    (lock_i),
        .restart_i (idle_timeout),
        .up_o      (link_up),
        .drop_o    (link_drop)
    );

    lnkmon_idle_watch #(
        .WIN_CYCLES (WIN_CYCLES),
        .RUN_LEN    (RUN_LEN)
    ) i_watch (
        .clk_i       (clk_i),
        .rst_ni      (rst_ni),
        .active_i    (link_up),
        .sym_valid_i (sym_valid_i),
        .sym_idle_i  (sym_idle_i),
        .timeout_o   (idle_timeout)
    );

    lnkmon_report i_report (
        .clk_i           (clk_i),
        .rst_ni          (rst_ni),
        .link_up_i       (link_up),
        .drop_i          (link_drop),
        .an_enable_i     (an_enable_i),
        .fail_override_i (fail_override_i),
        .stat_read_i     (stat_read_i),
        .stat_latched_o  (stat_latched_o),
        .reneg_o         (reneg_req_o),
        .tx_allow_o      (tx_allow_o),
        .flp_req_o       (flp_req_o)
    );

    assign link_up_o = link_up;

    // R4
    timeout_drops_link_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        idle_timeout |=> !link_up_o);

endmodule

// File: tb/test_link100_integrity_mon.sv
`timescale 1ns/1ps
module test_link100_integrity_mon;
    localparam int QUAL = 20;
    localparam int WIN  = 40;
    localparam int RUN  = 4;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic lock = 1'b0, sv = 1'b0, si = 1'b0, an = 1'b1, ovr = 1'b0, rd = 1'b0;
    logic link_up, stat_lat, reneg, tx_allow, flp;

    int checks = 0;
    int errors = 0;
    int cyc = 0;
    bit done = 1'b0;

    // behavioural reference
    int  m_held = 0, m_run = 0, m_age = 0;
    bit  m_up = 0, m_lat = 0, m_reneg = 0;

    always #2 clk = ~clk;

    link100_integrity_mon #(
        .QUAL_CYCLES (QUAL),
        .WIN_CYCLES  (WIN),
        .RUN_LEN     (RUN)
    ) i_link100_integrity_mon (
        .clk_i           (clk),
        .rst_ni          (rst_n),
        .lock_i          (lock),
        .sym_valid_i     (sv),
        .sym_idle_i      (si),
        .an_enable_i     (an),
        .fail_override_i (ovr),
        .stat_read_i     (rd),
        .link_up_o       (link_up),
        .stat_latched_o  (stat_lat),
        .reneg_req_o     (reneg),
        .tx_allow_o      (tx_allow),
        .flp_req_o       (flp)
    );

    task automatic check(input string req, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s at cycle %0d: actual %b expected %b", req, cyc, act, exp);
        end
    endtask

    // reference model, one step per edge
    always @(posedge clk) begin
        bit was_up;
        bit failed;
        cyc++;
        if (!rst_n) begin
            m_held = 0; m_run = 0; m_age = 0; m_up = 0; m_lat = 0; m_reneg = 0;
        end else begin
            was_up = m_up;
            failed = 0;
            if (!lock) begin
                failed = m_up;
                m_up = 0; m_held = 0; m_run = 0; m_age = 0;
            end else if (m_up) begin
                if (sv) m_run = si ? m_run + 1 : 0;
                if (m_run >= RUN) begin
                    m_run = 0; m_age = 0;
                end else if (m_age >= WIN - 1) begin
                    failed = 1;
                    m_up = 0; m_held = 0; m_run = 0; m_age = 0;
                end else begin
                    m_age++;
                end
            end else begin
                m_held++;
                if (m_held >= QUAL) begin
                    m_up = 1; m_held = 0; m_run = 0; m_age = 0;
                end
            end
            m_reneg = failed && an;
            if (failed) m_lat = 0;
            else if (rd) m_lat = was_up;
        end
    end

    // per-clock comparison, away from the edge
    always @(negedge clk) begin
        if (rst_n && !done) begin
            check("R2/R3/R4 link_up", link_up, m_up);
            check("R7 stat_latched", stat_lat, m_lat);
            check("R6 reneg_req", reneg, m_reneg);
            check("R8 tx_allow", tx_allow, m_up || (ovr && !an));
            check("R9 flp_req", flp, an && !m_up);
        end
    end

    task automatic step(input int n);
        repeat (n) begin
            @(posedge clk);
            #1;
        end
    endtask

    task automatic idle_stream(input int n, input int gap);
        for (int i = 0; i < n; i++) begin
            sv = (gap == 0) || (i % (gap + 1) == 0);
            si = 1'b1;
            step(1);
        end
        sv = 1'b0;
    endtask

    task automatic broken_stream(input int n);
        for (int i = 0; i < n; i++) begin
            sv = 1'b1;
            si = (i % RUN) != (RUN - 1);
            step(1);
        end
        sv = 1'b0;
    endtask

    task automatic do_read;
        rd = 1'b1;
        step(1);
        rd = 1'b0;
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired: actual running expected finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin : stim
        step(3);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        check("R1 link_up", link_up, 1'b0);
        check("R1 stat_latched", stat_lat, 1'b0);
        check("R1 reneg", reneg, 1'b0);
        check("R1 flp", flp, 1'b1);
        check("R1 tx_allow", tx_allow, 1'b0);
        step(1);

        // R2 qualification: not up after QUAL-1 samples, up after QUAL
        lock = 1'b1;
        step(QUAL - 1);
        @(negedge clk);
        check("R2 not yet up", link_up, 1'b0);
        step(1);
        @(negedge clk);
        check("R2 up after qualification", link_up, 1'b1);
        step(1);

        // R5 steady idle keeps link up over several windows
        idle_stream(3 * WIN, 0);
        @(negedge clk);
        check("R5 link held by idle runs", link_up, 1'b1);
        do_read;
        @(negedge clk);
        check("R7 read loads current up", stat_lat, 1'b1);

        // R4 sparse idle symbols still build a run
        idle_stream(3 * WIN, 1);
        @(negedge clk);
        check("R4 gaps do not break run", link_up, 1'b1);

        // R4 runs broken before RUN_LEN: window expires
        broken_stream(WIN + 2);
        @(negedge clk);
        check("R4 link down after window", link_up, 1'b0);
        check("R7 latched low after failure", stat_lat, 1'b0);

        // R3 requalify, then lose lock
        step(QUAL + 2);
        idle_stream(10, 0);
        lock = 1'b0;
        step(1);
        @(negedge clk);
        check("R3 lock loss drops link", link_up, 1'b0);
        check("R6 reneg pulse on failure", reneg, 1'b1);
        step(1);
        @(negedge clk);
        check("R6 reneg single cycle", reneg, 1'b0);
        lock = 1'b1;
        step(QUAL / 2);
        lock = 1'b0;
        step(1);
        lock = 1'b1;
        step(QUAL - 1);
        @(negedge clk);
        check("R3 count restarted", link_up, 1'b0);
        step(1);

        // R8 override with auto-negotiation off, failure without renegotiate
        an = 1'b0;
        ovr = 1'b1;
        idle_stream(20, 0);
        rd = 1'b1;
        lock = 1'b0;
        step(1);
        rd = 1'b0;
        @(negedge clk);
        check("R7 failure beats read", stat_lat, 1'b0);
        check("R6 no reneg without AN", reneg, 1'b0);
        check("R8 override opens tx", tx_allow, 1'b1);
        check("R9 no flp without AN", flp, 1'b0);
        ovr = 1'b0;
        step(2);
        an = 1'b1;
        ovr = 1'b1;
        step(2);
        @(negedge clk);
        check("R8 override ignored with AN", tx_allow, 1'b0);
        step(2);

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule